// File: doc/BRIEF.md
# Global FIFO Error Halt Controller

This block sits beside the transmit and receive FIFOs of a multichannel serial cell engine and handles the two errors that cannot be pinned to one channel. When the transmit FIFO runs dry, no single channel can be blamed. The block then records a global underrun event and raises a scheduler-disabled flag. That flag stops transmission on every channel and holds the serial output at its idle level (logic high). When the receive FIFO overflows, the block records a global overrun event. It then stops reception on every channel and blocks every transfer of received data to memory.

The host handles both conditions through a small register port with four word addresses:
- address 0: the event register, write-one-to-clear.
- address 1: the interrupt mask register.
- address 2: the status word. Bit 0 is the disabled flag, read and write. Bit 1 is the receive halt, read only.
- address 3: the control word. Writing bit 0 as 1 gives a receive-restart pulse.

Writing 0 to status bit 0 restarts transmission. The cell scheduler can raise the disabled flag again at any time, so software reads the status word back at least 50 clocks after its write to confirm that the restart took effect.

Top module: `gfe_halt_ctrl`

## Requirements
- R1: After reset, every register reads 0, `tx_halt`, `rx_halt`, `dma_block` and `irq` are 0, and `tx_line` follows `tx_data`.
- R2: A cycle with `tx_fifo_underrun` high sets event bit 14 (value 0x4000 at address 0) at the next clock edge.
- R3: A cycle with `rx_fifo_overrun` high sets event bit 15 (value 0x8000 at address 0) at the next clock edge.
- R4: A write to address 0 clears each event bit whose data bit is 1. Data bits that are 0 leave the event bits unchanged. Event bits 0 to 13 always read 0.
- R5: If a clear write and a new event for the same bit fall in the same cycle, the bit is set after that edge.
- R6: An underrun sets the disabled flag (status bit 0) at the next edge. `tx_halt`, which stops all channels, follows the flag.
- R7: While `tx_halt` is 1, `tx_line` is 1 whatever `tx_data` is. Otherwise `tx_line` equals `tx_data`.
- R8: An overrun sets `rx_halt` and `dma_block` (status bit 1) at the next edge. Both stay set until a write to address 3 with data bit 0 equal to 1. An overrun in that same cycle keeps them set.
- R9: Only a write to address 2 releases the transmit halt, and only with data bit 0 equal to 0. Clearing the underrun event does not release it.
- R10: If `sched_dis_set`, or an underrun, falls in the same cycle as a host write of 0 to the flag, the flag is set after that edge. The flag is set by either one alone as well.
- R11: `irq` is 1 exactly when some event bit is set and the mask bit at the same position is 1. All 16 mask bits read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_fifo_underrun | input | 1 | Transmit FIFO ran empty this cycle |
| rx_fifo_overrun | input | 1 | Receive FIFO overflowed this cycle |
| sched_dis_set | input | 1 | Scheduler forces the disabled flag on |
| tx_data | input | 1 | Serial data from the transmitter |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address (read and write) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| tx_halt | output | 1 | Transmission stopped on all channels |
| tx_line | output | 1 | Serial line, idle high while halted |
| rx_halt | output | 1 | Reception stopped on all channels |
| dma_block | output | 1 | Transfers of received data to memory blocked |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench builds the block with its default 16-bit register word and the event bits at positions 14 and 15. These are the positions that the read-back values in the requirements depend on. With only two live event bits, random writes of all-ones, all-zero and mixed data to every address reach all four combinations of set and clear on each bit. They also reach every ordering of underrun, scheduler set and host clear on the disabled flag. The overrun pulse lands on the restart write often enough that the same-cycle priorities are exercised repeatedly.

// File: rtl/gfe_pkg.sv
package gfe_pkg;
  localparam int REG_W      = 16;
  localparam int ADDR_W     = 2;
  localparam int EVT_UN_POS = 14;
  localparam int EVT_OV_POS = 15;
  localparam int N_EVT      = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_EVT  = 2'd0,
    SEL_MASK = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  // place the two live event bits into a register word
  function automatic logic [REG_W-1:0] evt_word(input logic [N_EVT-1:0] ev);
    logic [REG_W-1:0] w;
    w = '0;
    w[EVT_UN_POS] = ev[0];
    w[EVT_OV_POS] = ev[1];
    return w;
  endfunction

  // pull the clear request for each live event bit from write data
  function automatic logic [N_EVT-1:0] evt_pick(input logic [REG_W-1:0] w);
    return {w[EVT_OV_POS], w[EVT_UN_POS]};
  endfunction

  function automatic logic [REG_W-1:0] stat_word(input logic dis, input logic rxh);
    logic [REG_W-1:0] w;
    w = '0;
    w[0] = dis;
    w[1] = rxh;
    return w;
  endfunction

  // sticky bit: a new event outranks a clear in the same cycle
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/gfe_evt_bits.sv
module gfe_evt_bits #(
  parameter int N = gfe_pkg::N_EVT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= gfe_pkg::sticky_next(q[i], set[i], clr[i]);
    end

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
    p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr[i]) |=> q[i]);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !q[i]);
  end
endmodule

// File: rtl/gfe_tx_halt.sv
module gfe_tx_halt (
  input  logic clk,
  input  logic rst_n,
  input  logic underrun,
  input  logic sched_set,
  input  logic host_wr,
  input  logic host_val,
  input  logic tx_data,
  output logic dis,
  output logic tx_line
);
  logic force_on;
  assign force_on = underrun | sched_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dis <= 1'b0;
    else if (force_on) dis <= 1'b1;
    else if (host_wr)  dis <= host_val;
  end

  assign tx_line = dis | tx_data;

  p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
    force_on |=> dis);
  p_un_dis_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> dis);
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_val && !force_on) |=> !dis);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dis && !host_wr) |=> dis);
endmodule

// File: rtl/gfe_rx_halt.sv
module gfe_rx_halt (
  input  logic clk,
  input  logic rst_n,
  input  logic overrun,
  input  logic restart,
  output logic rx_halt,
  output logic dma_block
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_halt <= 1'b0;
    else        rx_halt <= gfe_pkg::sticky_next(rx_halt, overrun, restart);
  end

  assign dma_block = rx_halt;

  p_ov_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> (rx_halt && dma_block));
  p_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_halt && !restart) |=> rx_halt);
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !overrun) |=> !rx_halt);
endmodule

// File: rtl/gfe_halt_ctrl.sv
module gfe_halt_ctrl #(
  parameter int REG_W  = gfe_pkg::REG_W,
  parameter int ADDR_W = gfe_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_fifo_underrun,
  input  logic              rx_fifo_overrun,
  input  logic              sched_dis_set,
  input  logic              tx_data,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              tx_halt,
  output logic              tx_line,
  output logic              rx_halt,
  output logic              dma_block,
  output logic              irq
);
  import gfe_pkg::*;

  reg_sel_e          sel;
  logic              wr_evt, wr_mask, wr_stat, wr_ctrl;
  logic [N_EVT-1:0]  evt_set, evt_clr, evt_q;
  logic [REG_W-1:0]  mask_q, evt_vec;
  logic              dis_q, rx_restart;

  assign sel     = reg_sel_e'(reg_addr);
  assign wr_evt  = reg_wr && (sel == SEL_EVT);
  assign wr_mask = reg_wr && (sel == SEL_MASK);
  assign wr_stat = reg_wr && (sel == SEL_STAT);
  assign wr_ctrl = reg_wr && (sel == SEL_CTRL);

  assign evt_set    = {rx_fifo_overrun, tx_fifo_underrun};
  assign evt_clr    = wr_evt ? evt_pick(reg_wdata) : '0;
  assign rx_restart = wr_ctrl && reg_wdata[0];

  gfe_evt_bits #(.N(N_EVT)) u_evt (
    .clk(clk), .rst_n(rst_n), .set(evt_set), .clr(evt_clr), .q(evt_q)
  );

  gfe_tx_halt u_tx (
    .clk(clk), .rst_n(rst_n), .underrun(tx_fifo_underrun),
    .sched_set(sched_dis_set), .host_wr(wr_stat), .host_val(reg_wdata[0]),
    .tx_data(tx_data), .dis(dis_q), .tx_line(tx_line)
  );

  gfe_rx_halt u_rx (
    .clk(clk), .rst_n(rst_n), .overrun(rx_fifo_overrun),
    .restart(rx_restart), .rx_halt(rx_halt), .dma_block(dma_block)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata;
  end

  assign evt_vec = evt_word(evt_q);
  assign tx_halt = dis_q;
  assign irq     = |(evt_vec & mask_q);

  always_comb begin
    unique case (sel)
      SEL_EVT:  reg_rdata = evt_vec;
      SEL_MASK: reg_rdata = mask_q;
      SEL_STAT: reg_rdata = stat_word(dis_q, rx_halt);
      default:  reg_rdata = '0;
    endcase
  end

  p_un_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_underrun |=> evt_vec[EVT_UN_POS]);
  p_ov_evt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_overrun |=> evt_vec[EVT_OV_POS]);
  p_idle_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_halt |-> tx_line);
  p_mask_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));
endmodule

// File: tb/gfe_halt_ctrl_test.sv
module gfe_halt_ctrl_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        und = 1'b0, ovr = 1'b0, sch = 1'b0, txd = 1'b0, wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        tx_halt, tx_line, rx_halt, dma_block, irq;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic        m_un = 0, m_ov = 0, m_dis = 0, m_rxh = 0;
  logic [15:0] m_mask = 0;

  always #(CLK_P/2) clk = ~clk;

  gfe_halt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tx_fifo_underrun(und), .rx_fifo_overrun(ovr),
    .sched_dis_set(sch), .tx_data(txd), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .tx_halt(tx_halt), .tx_line(tx_line),
    .rx_halt(rx_halt), .dma_block(dma_block), .irq(irq)
  );

  function automatic logic [15:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return (16'(m_un) << 14) | (16'(m_ov) << 15);
      2'd1:    return m_mask;
      2'd2:    return {14'd0, m_rxh, m_dis};
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (m_un & m_mask[14]) | (m_ov & m_mask[15]);
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic wev, wst, wct;
    wev = wr && addr == 2'd0;
    wst = wr && addr == 2'd2;
    wct = wr && addr == 2'd3;
    m_un  = und | (m_un & ~(wev & wdata[14]));
    m_ov  = ovr | (m_ov & ~(wev & wdata[15]));
    if (wr && addr == 2'd1) m_mask = wdata;
    m_dis = und | sch | (wst ? wdata[0] : m_dis);
    m_rxh = ovr | (m_rxh & ~(wct & wdata[0]));
  endtask

  task automatic step(input logic u, input logic o, input logic s, input logic d,
                      input logic w, input logic [1:0] a, input logic [15:0] v);
    @(negedge clk);
    und = u; ovr = o; sch = s; txd = d; wr = w; addr = a; wdata = v;
    @(posedge clk);
    model_edge();
    #(CLK_P/4);
    und = 0; ovr = 0; sch = 0; wr = 0;
  endtask

  task automatic check_all();
    chk("R6 tx_halt", 16'(tx_halt), 16'(m_dis));
    chk("R7 tx_line", 16'(tx_line), 16'(m_dis | txd));
    chk("R8 rx_halt", 16'(rx_halt), 16'(m_rxh));
    chk("R8 dma_block", 16'(dma_block), 16'(m_rxh));
    chk("R11 irq", 16'(irq), 16'(exp_irq()));
    chk("R4 rdata", rdata, exp_read(addr));
  endtask

  task automatic rd(input logic [1:0] a);
    step(0, 0, 0, txd, 0, a, 16'h0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a));
      chk("R1 reset reg", rdata, 16'h0);
    end
    txd = 1'b0; #1;
    chk("R1 line follows 0", 16'(tx_line), 16'd0);
    txd = 1'b1; #1;
    chk("R1 line follows 1", 16'(tx_line), 16'd1);
    chk("R1 flags", {12'd0, tx_halt, rx_halt, dma_block, irq}, 16'h0);

    // R2 and R6: underrun
    step(1, 0, 0, 0, 0, 2'd0, 16'h0);
    chk("R2 underrun event", rdata, 16'h4000);
    chk("R6 halt", 16'(tx_halt), 16'd1);
    chk("R7 idle high", 16'(tx_line), 16'd1);
    rd(2'd2);
    chk("R6 dis flag", rdata, 16'h0001);

    // R4: zero write leaves event bits
    step(0, 0, 0, 0, 1, 2'd0, 16'h3FFF);
    chk("R4 zero write keeps", rdata, 16'h4000);
    // R9: clearing event does not release tx
    step(0, 0, 0, 0, 1, 2'd0, 16'hC000);
    chk("R4 w1c clears", rdata, 16'h0000);
    chk("R9 still halted", 16'(tx_halt), 16'd1);
    step(0, 0, 0, 0, 1, 2'd2, 16'h0000);
    chk("R9 released", 16'(tx_halt), 16'd0);
    repeat (50) rd(2'd2);
    chk("R9 readback after 50", rdata, 16'h0000);

    // R10: scheduler set wins over host clear
    step(0, 0, 1, 0, 1, 2'd2, 16'h0000);
    chk("R10 sched wins", rdata, 16'h0001);
    step(0, 0, 0, 0, 1, 2'd2, 16'h0000);
    step(1, 0, 0, 0, 1, 2'd2, 16'h0000);
    chk("R10 underrun wins", rdata, 16'h0001);
    step(0, 0, 0, 0, 1, 2'd2, 16'h0000);

    // R3 and R8: overrun
    step(0, 1, 0, 0, 0, 2'd0, 16'h0);
    chk("R3 overrun event", rdata, 16'hC000 & {m_ov, m_un, 14'd0});
    chk("R3 bit15", 16'(rdata[15]), 16'd1);
    chk("R8 rx halt", 16'(rx_halt), 16'd1);
    chk("R8 dma block", 16'(dma_block), 16'd1);
    // R5: clear and new event same cycle
    step(0, 1, 0, 0, 1, 2'd0, 16'hC000);
    chk("R5 set beats clear", 16'(rdata[15]), 16'd1);
    step(0, 1, 0, 0, 1, 2'd3, 16'h0001);
    chk("R8 overrun beats restart", 16'(rx_halt), 16'd1);
    step(0, 0, 0, 0, 1, 2'd3, 16'h0000);
    chk("R8 zero ctrl keeps", 16'(rx_halt), 16'd1);
    step(0, 0, 0, 0, 1, 2'd3, 16'h0001);
    chk("R8 restart", 16'(rx_halt), 16'd0);
    chk("R8 dma released", 16'(dma_block), 16'd0);

    // R11: mask
    step(0, 0, 0, 0, 1, 2'd1, 16'h8000);
    chk("R11 irq masked on", 16'(irq), 16'd1);
    chk("R11 mask readback", rdata, 16'h8000);
    step(0, 0, 0, 0, 1, 2'd1, 16'h4000);
    chk("R11 irq other bit", 16'(irq), 16'(m_un));
    step(0, 0, 0, 0, 1, 2'd0, 16'hFFFF);
    chk("R11 irq off", 16'(irq), 16'd0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] v;
      int k;
      k = $urandom_range(0, 3);
      v = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0000 : 16'($urandom);
      step(($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0),
           ($urandom_range(0, 31) == 0), 1'($urandom),
           1'($urandom), 2'($urandom), v);
      check_all();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule